// File: doc/BRIEF.md
# Time-Locked Evoked Response Averager

This block records a stream of unsigned EEG samples into an on-chip dual-port memory. Recording starts when the trigger of the stimulus that flashes first makes a rising edge. The block then produces the ensemble-averaged response for each of four stimuli. All four flash at the same rate, and each one fires a fixed number of samples after the one before it. One recording therefore holds every epoch of every stimulus. The start address of each epoch follows from the flash count `N` and the stagger `D`, so the block never needs a second trigger.

After the last needed sample is stored, the block reads back each epoch point. It sums that point over the `N` flashes and divides the sum by `N`. When `N` is a power of two the division is a right shift. Otherwise a sequential restoring divider does it. The results leave as a stream tagged with the stimulus number and the position in the epoch, followed by a one-cycle completion pulse. Filtering and classification happen downstream.

Top module: `erp_averager`

## Requirements
- R1: The trigger input is synchronised to the clock and acts on its 0-to-1 transition. A rise held for at least 2 clocks starts a recording. The first sample presented with `smp_valid` high 4 or more cycles after the rise is stored at address 0. Samples presented while no recording is running are never stored.
- R2: Once a trigger has been accepted, further trigger rises are ignored until the `done` pulse of that run.
- R3: `flash_cnt` and `stim_delay` are captured when the trigger is accepted. Changing them later has no effect on that run's results.
- R4: A recording stores exactly `(N-1)*4*D + 3*D + L` valid samples at consecutive addresses, with `L` = 16 at default parameters. Valid samples after that are not stored.
- R5: Epoch `k` (0 to N-1) of stimulus `s` (0 to 3) begins at address `k*4*D + s*D`.
- R6: Each output value is `floor(sum / N)`, where the sum runs over the `N` epochs at one point. For `N` = 1 the output equals the recorded sample.
- R7: A power-of-two `N` is handled by a shift and any other `N` by the sequential divider. Both give the same floor result.
- R8: The sum holds `N * 65535` for any `N` up to 255 without overflow, so full-scale input averages back to full scale.
- R9: Results come out in stimulus order 0, 1, 2, 3. Each stimulus gives `L` results with `avg_idx` counting 0 to `L-1`, and `avg_stim` carries the stimulus number. A run gives 64 results in total.
- R10: `done` is high for exactly one cycle, the cycle right after the last result. It is never high together with `avg_valid`.
- R11: While reset is high and right after it, `avg_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Unsigned sample |
| trig_in | input | 1 | Trigger of the earliest-flashing stimulus, asynchronous |
| flash_cnt | input | 8 | Flash count N, 1 to 255 |
| stim_delay | input | 10 | Stagger D between neighbouring stimuli, in samples |
| avg_valid | output | 1 | Averaged result present |
| avg_data | output | 16 | Averaged result |
| avg_stim | output | 2 | Stimulus number of the result |
| avg_idx | output | 4 | Position of the result in its epoch |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The readback produces one result every `N+3` cycles when `N` is a power of two and every `N+27` cycles otherwise. These counts cover the `N` reads, one drain cycle and the division. The first result follows shortly after the final recorded sample. The bench does not pin each result to an exact cycle. Its behavioural model predicts the ordered list of results and compares every cycle on which `avg_valid` is high against the head of that list. It bounds each run with a deadline derived from those per-result counts. The `done` pulse is checked to the exact cycle: it must come immediately after the last result, with the expected list then empty.

// File: rtl/erp_avg_pkg.sv
package erp_avg_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_REC,
    CAP_HOLD
  } cap_state_e;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_ISSUE,
    RD_DRAIN,
    RD_DIV,
    RD_FIN
  } rd_state_e;
endpackage

// File: rtl/erp_trig_edge.sv
module erp_trig_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic trig_rise
);
  logic [SYNC:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC-1:0], trig_in};
  end

  assign trig_rise = chain[SYNC-1] & ~chain[SYNC];
endmodule

// File: rtl/erp_sample_ram.sv
module erp_sample_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/erp_capture.sv
module erp_capture
  import erp_avg_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 10,
  parameter int NW        = 8,
  parameter int DLW       = 10,
  parameter int NSTIM     = 4,
  parameter int EPOCH_LEN = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig_rise,
  input  logic           smp_valid,
  input  logic [DW-1:0]  smp_data,
  input  logic [NW-1:0]  flash_cnt,
  input  logic [DLW-1:0] stim_delay,
  input  logic           rd_fin,
  output logic           we,
  output logic [AW-1:0]  waddr,
  output logic [DW-1:0]  wdata,
  output logic           cap_done,
  output logic [NW-1:0]  n_lat,
  output logic [DLW-1:0] d_lat
);
  localparam int RLW = NW + DLW + $clog2(NSTIM) + $clog2(EPOCH_LEN) + 2;

  cap_state_e     state;
  logic [RLW-1:0] wcnt;
  logic [RLW-1:0] rec_len;
  logic [RLW-1:0] rec_len_c;
  logic [RLW-1:0] n_w;
  logic [RLW-1:0] d_w;

  assign n_w = RLW'(flash_cnt);
  assign d_w = RLW'(stim_delay);
  assign rec_len_c = (n_w - RLW'(1)) * (d_w * RLW'(NSTIM))
                   + d_w * RLW'(NSTIM - 1) + RLW'(EPOCH_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CAP_IDLE;
      wcnt     <= '0;
      rec_len  <= '0;
      n_lat    <= '0;
      d_lat    <= '0;
      cap_done <= 1'b0;
    end else begin
      cap_done <= 1'b0;
      case (state)
        CAP_IDLE: begin
          if (trig_rise) begin
            n_lat   <= flash_cnt;
            d_lat   <= stim_delay;
            rec_len <= rec_len_c;
            wcnt    <= '0;
            state   <= CAP_REC;
          end
        end
        CAP_REC: begin
          if (smp_valid) begin
            wcnt <= wcnt + RLW'(1);
            if (wcnt == rec_len - RLW'(1)) begin
              cap_done <= 1'b1;
              state    <= CAP_HOLD;
            end
          end
        end
        CAP_HOLD: begin
          if (rd_fin) state <= CAP_IDLE;
        end
        default: state <= CAP_IDLE;
      endcase
    end
  end

  assign we    = (state == CAP_REC) && smp_valid;
  assign waddr = wcnt[AW-1:0];
  assign wdata = smp_data;
endmodule

// File: rtl/erp_epoch_reader.sv
module erp_epoch_reader
  import erp_avg_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 10,
  parameter int NW        = 8,
  parameter int DLW       = 10,
  parameter int NSTIM     = 4,
  parameter int EPOCH_LEN = 16,
  parameter int ACCW      = DW + NW
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [NW-1:0]                n_lat,
  input  logic [DLW-1:0]               d_lat,
  output logic                         re,
  output logic [AW-1:0]                raddr,
  input  logic [DW-1:0]                rdata,
  output logic                         sum_vld,
  output logic [ACCW-1:0]              sum,
  input  logic                         div_done,
  output logic [$clog2(NSTIM)-1:0]     cur_stim,
  output logic [$clog2(EPOCH_LEN)-1:0] cur_idx,
  output logic                         fin
);
  localparam int SW = $clog2(NSTIM);
  localparam int IW = $clog2(EPOCH_LEN);
  localparam int PW = AW + DLW + SW + 1;

  rd_state_e       state;
  logic [SW-1:0]   s_cnt;
  logic [IW-1:0]   i_cnt;
  logic [NW-1:0]   k_cnt;
  logic [AW-1:0]   stim_base;
  logic [AW-1:0]   addr;
  logic [AW-1:0]   step;
  logic [AW-1:0]   stagger;
  logic            last_k;
  logic            en_q;
  logic            first_q;
  logic            last_q;
  logic [ACCW-1:0] acc;

  assign step    = AW'(PW'(d_lat) * PW'(NSTIM));
  assign stagger = AW'(d_lat);
  assign last_k  = (k_cnt == n_lat - NW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      acc     <= '0;
      sum_vld <= 1'b0;
    end else begin
      en_q    <= re;
      first_q <= re && (k_cnt == '0);
      last_q  <= re && last_k;
      if (en_q) acc <= first_q ? ACCW'(rdata) : acc + ACCW'(rdata);
      sum_vld <= en_q && last_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_IDLE;
      s_cnt     <= '0;
      i_cnt     <= '0;
      k_cnt     <= '0;
      stim_base <= '0;
      addr      <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (start) begin
            s_cnt     <= '0;
            i_cnt     <= '0;
            k_cnt     <= '0;
            stim_base <= '0;
            addr      <= '0;
            state     <= RD_ISSUE;
          end
        end
        RD_ISSUE: begin
          addr  <= addr + step;
          k_cnt <= k_cnt + NW'(1);
          if (last_k) state <= RD_DRAIN;
        end
        RD_DRAIN: state <= RD_DIV;
        RD_DIV: begin
          if (div_done) begin
            k_cnt <= '0;
            if (i_cnt == IW'(EPOCH_LEN - 1)) begin
              i_cnt <= '0;
              if (s_cnt == SW'(NSTIM - 1)) begin
                state <= RD_FIN;
              end else begin
                s_cnt     <= s_cnt + SW'(1);
                stim_base <= stim_base + stagger;
                addr      <= stim_base + stagger;
                state     <= RD_ISSUE;
              end
            end else begin
              i_cnt <= i_cnt + IW'(1);
              addr  <= stim_base + AW'(i_cnt) + AW'(1);
              state <= RD_ISSUE;
            end
          end
        end
        RD_FIN:  state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign re       = (state == RD_ISSUE);
  assign raddr    = addr;
  assign sum      = acc;
  assign cur_stim = s_cnt;
  assign cur_idx  = i_cnt;
  assign fin      = (state == RD_FIN);
endmodule

// File: rtl/erp_divider.sv
module erp_divider #(
  parameter int DW   = 16,
  parameter int NW   = 8,
  parameter int ACCW = DW + NW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [ACCW-1:0] dividend,
  input  logic [NW-1:0]   divisor,
  output logic            done,
  output logic [DW-1:0]   quo
);
  localparam int CW  = $clog2(ACCW + 1);
  localparam int SHW = $clog2(NW);

  logic            busy;
  logic [CW-1:0]   cnt;
  logic [NW-1:0]   rem;
  logic [ACCW-1:0] dvd;
  logic [NW:0]     rem_sh;
  logic            ge;
  logic [NW-1:0]   rem_nx;
  logic [ACCW-1:0] dvd_nx;
  logic            is_pow2;
  logic [SHW-1:0]  shamt;

  assign is_pow2 = ($countones(divisor) == 1);

  always_comb begin
    shamt = '0;
    for (int b = 0; b < NW; b++) begin
      if (divisor[b]) shamt = SHW'(b);
    end
  end

  assign rem_sh = {rem, dvd[ACCW-1]};
  assign ge     = (rem_sh >= {1'b0, divisor});
  assign rem_nx = ge ? NW'(rem_sh - {1'b0, divisor}) : NW'(rem_sh);
  assign dvd_nx = {dvd[ACCW-2:0], ge};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      dvd  <= '0;
      done <= 1'b0;
      quo  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        if (is_pow2) begin
          quo  <= DW'(dividend >> shamt);
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= '0;
          rem  <= '0;
          dvd  <= dividend;
        end
      end else if (busy) begin
        rem <= rem_nx;
        dvd <= dvd_nx;
        cnt <= cnt + CW'(1);
        if (cnt == CW'(ACCW - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= DW'(dvd_nx);
        end
      end
    end
  end
endmodule

// File: rtl/erp_averager.sv
module erp_averager #(
  parameter int DW        = 16,
  parameter int NW        = 8,
  parameter int AW        = 10,
  parameter int DLW       = 10,
  parameter int NSTIM     = 4,
  parameter int EPOCH_LEN = 16,
  parameter int SYNC      = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smp_valid,
  input  logic [DW-1:0]                smp_data,
  input  logic                         trig_in,
  input  logic [NW-1:0]                flash_cnt,
  input  logic [DLW-1:0]               stim_delay,
  output logic                         avg_valid,
  output logic [DW-1:0]                avg_data,
  output logic [$clog2(NSTIM)-1:0]     avg_stim,
  output logic [$clog2(EPOCH_LEN)-1:0] avg_idx,
  output logic                         done
);
  localparam int ACCW = DW + NW;
  localparam int SW   = $clog2(NSTIM);
  localparam int IW   = $clog2(EPOCH_LEN);

  logic            trig_rise;
  logic            we;
  logic [AW-1:0]   waddr;
  logic [DW-1:0]   wdata;
  logic            re;
  logic [AW-1:0]   raddr;
  logic [DW-1:0]   rdata;
  logic            cap_done;
  logic [NW-1:0]   n_lat;
  logic [DLW-1:0]  d_lat;
  logic            sum_vld;
  logic [ACCW-1:0] sum;
  logic            div_done;
  logic [DW-1:0]   quo;
  logic [SW-1:0]   cur_stim;
  logic [IW-1:0]   cur_idx;
  logic            rd_fin;

  erp_trig_edge #(.SYNC(SYNC)) trig_i (
    .clk(clk), .rst(rst), .trig_in(trig_in), .trig_rise(trig_rise)
  );

  erp_capture #(
    .DW(DW), .AW(AW), .NW(NW), .DLW(DLW), .NSTIM(NSTIM), .EPOCH_LEN(EPOCH_LEN)
  ) cap_i (
    .clk(clk), .rst(rst), .trig_rise(trig_rise), .smp_valid(smp_valid),
    .smp_data(smp_data), .flash_cnt(flash_cnt), .stim_delay(stim_delay),
    .rd_fin(rd_fin), .we(we), .waddr(waddr), .wdata(wdata),
    .cap_done(cap_done), .n_lat(n_lat), .d_lat(d_lat)
  );

  erp_sample_ram #(.DW(DW), .AW(AW)) ram_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(rdata)
  );

  erp_epoch_reader #(
    .DW(DW), .AW(AW), .NW(NW), .DLW(DLW), .NSTIM(NSTIM),
    .EPOCH_LEN(EPOCH_LEN), .ACCW(ACCW)
  ) rd_i (
    .clk(clk), .rst(rst), .start(cap_done), .n_lat(n_lat), .d_lat(d_lat),
    .re(re), .raddr(raddr), .rdata(rdata), .sum_vld(sum_vld), .sum(sum),
    .div_done(div_done), .cur_stim(cur_stim), .cur_idx(cur_idx), .fin(rd_fin)
  );

  erp_divider #(.DW(DW), .NW(NW), .ACCW(ACCW)) div_i (
    .clk(clk), .rst(rst), .start(sum_vld), .dividend(sum), .divisor(n_lat),
    .done(div_done), .quo(quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_valid <= 1'b0;
      avg_data  <= '0;
      avg_stim  <= '0;
      avg_idx   <= '0;
      done      <= 1'b0;
    end else begin
      avg_valid <= div_done;
      done      <= rd_fin;
      if (div_done) begin
        avg_data <= quo;
        avg_stim <= cur_stim;
        avg_idx  <= cur_idx;
      end
    end
  end
endmodule

// File: rtl/erp_averager_chk.sv
module erp_averager_chk #(
  parameter int NSTIM     = 4,
  parameter int EPOCH_LEN = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         avg_valid,
  input logic [$clog2(NSTIM)-1:0]     avg_stim,
  input logic [$clog2(EPOCH_LEN)-1:0] avg_idx,
  input logic                         done
);
  localparam int SW    = $clog2(NSTIM);
  localparam int IW    = $clog2(EPOCH_LEN);
  localparam int TOTAL = NSTIM * EPOCH_LEN;
  localparam int OW    = $clog2(TOTAL + 1);

  logic [IW-1:0] exp_idx;
  logic [SW-1:0] exp_stim;
  logic [OW-1:0] out_cnt;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      exp_idx  <= '0;
      exp_stim <= '0;
      out_cnt  <= '0;
    end else if (avg_valid) begin
      out_cnt <= out_cnt + OW'(1);
      if (exp_idx == IW'(EPOCH_LEN - 1)) begin
        exp_idx  <= '0;
        exp_stim <= exp_stim + SW'(1);
      end else begin
        exp_idx <= exp_idx + IW'(1);
      end
    end
  end

  p_done_after_last_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(avg_valid));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_apart_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !avg_valid);

  p_idx_order_r9: assert property (@(posedge clk) disable iff (rst)
    avg_valid |-> avg_idx == exp_idx);

  p_stim_order_r9: assert property (@(posedge clk) disable iff (rst)
    avg_valid |-> avg_stim == exp_stim);

  p_run_count_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> out_cnt == OW'(TOTAL));
endmodule

bind erp_averager erp_averager_chk #(.NSTIM(NSTIM), .EPOCH_LEN(EPOCH_LEN)) chk_i (
  .clk(clk), .rst(rst), .avg_valid(avg_valid), .avg_stim(avg_stim),
  .avg_idx(avg_idx), .done(done)
);

// File: tb/erp_averager_tb_top.sv
module erp_averager_tb_top;
  localparam int L = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        trig_in = 1'b0;
  logic [7:0]  flash_cnt = 8'd1;
  logic [9:0]  stim_delay = '0;
  logic        avg_valid;
  logic [15:0] avg_data;
  logic [1:0]  avg_stim;
  logic [3:0]  avg_idx;
  logic        done;

  int total = 0;
  int bad = 0;
  int done_seen = 0;
  int cycles = 0;
  bit prev_valid = 1'b0;
  string cur_tag = "R11";
  logic [31:0] lcg = 32'h1357_9bdf;
  int q_data[$];
  int q_stim[$];
  int q_idx[$];

  always #4 clk = ~clk;

  erp_averager dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig_in(trig_in), .flash_cnt(flash_cnt), .stim_delay(stim_delay),
    .avg_valid(avg_valid), .avg_data(avg_data), .avg_stim(avg_stim),
    .avg_idx(avg_idx), .done(done)
  );

  function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Reference monitor: every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      if (avg_valid) begin
        if (q_data.size() == 0) begin
          chk(1'b0, "R9", "unexpected result", avg_data, -1);
        end else begin
          chk(avg_data == 16'(q_data[0]), cur_tag, "average", avg_data, q_data[0]);
          chk(avg_stim == 2'(q_stim[0]), "R9", "stimulus", avg_stim, q_stim[0]);
          chk(avg_idx == 4'(q_idx[0]), "R9", "index", avg_idx, q_idx[0]);
          void'(q_data.pop_front());
          void'(q_stim.pop_front());
          void'(q_idx.pop_front());
        end
      end
      if (done) begin
        chk(q_data.size() == 0, "R10", "results left at done", q_data.size(), 0);
        chk(prev_valid, "R10", "done follows last result", prev_valid, 1);
        chk(!avg_valid, "R10", "done with valid", avg_valid, 0);
        done_seen++;
      end
      prev_valid = avg_valid;
      if (cycles > 150000) begin
        chk(1'b0, "R10", "watchdog expired", cycles, 150000);
        finish_run();
      end
    end
  end

  function automatic int gen(int pat, int j);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    if (pat == 1) return 65535 - (j % 3);
    return int'(lcg[23:8]);
  endfunction

  task automatic run_case(int n, int d, int pat, bit disturb, string tag);
    int rlen;
    int rec[$];
    int base_done;
    int limit;
    int t;
    longint acc;
    rlen = (n - 1) * 4 * d + 3 * d + L;
    cur_tag = tag;
    // R1: samples offered before the trigger must never be stored
    for (int j = 0; j < 6; j++) begin
      @(posedge clk); #1;
      smp_valid = 1'b1;
      smp_data = 16'(16'h1234 + j);
    end
    @(posedge clk); #1;
    smp_valid = 1'b0;
    flash_cnt = 8'(n);
    stim_delay = 10'(d);
    trig_in = 1'b1;
    repeat (2) @(posedge clk);
    #1 trig_in = 1'b0;
    repeat (4) @(posedge clk);
    for (int j = 0; j < rlen; j++) rec.push_back(gen(pat, j));
    // R5 R6: epoch k of stimulus s starts at k*4*d + s*d, average is the floor
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < L; i++) begin
        acc = 0;
        for (int k = 0; k < n; k++) acc += rec[k * 4 * d + s * d + i];
        q_data.push_back(int'(acc / n));
        q_stim.push_back(s);
        q_idx.push_back(i);
      end
    end
    base_done = done_seen;
    for (int j = 0; j < rlen; j++) begin
      @(posedge clk); #1;
      if (j % 5 == 4) begin
        smp_valid = 1'b0;
        @(posedge clk); #1;
      end
      smp_valid = 1'b1;
      smp_data = 16'(rec[j]);
      if (disturb && j == rlen / 2) begin
        // R2 R3: new trigger and new settings mid-recording have no effect
        flash_cnt = 8'(n + 1);
        stim_delay = 10'(d + 2);
        trig_in = 1'b1;
      end
      if (disturb && j == rlen / 2 + 3) trig_in = 1'b0;
    end
    // R4: samples beyond the recording length are not stored
    for (int j = 0; j < 20; j++) begin
      @(posedge clk); #1;
      smp_valid = 1'b1;
      smp_data = 16'hABCD;
      if (disturb && j == 5) trig_in = 1'b1;
      if (disturb && j == 8) trig_in = 1'b0;
    end
    @(posedge clk); #1;
    smp_valid = 1'b0;
    limit = 64 * (n + 40) + 200;
    t = 0;
    while (done_seen == base_done && t < limit) begin
      @(posedge clk);
      t++;
    end
    #1;
    chk(done_seen == base_done + 1, "R10", "done count for run", done_seen - base_done, 1);
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(avg_valid == 1'b0, "R11", "valid after reset", avg_valid, 0);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    run_case(4, 8, 0, 1'b1, "R1 R2 R3 R4 R5 R7");
    run_case(3, 8, 0, 1'b0, "R6 R7");
    run_case(1, 5, 0, 1'b0, "R6");
    run_case(6, 3, 0, 1'b1, "R5 R7");
    run_case(250, 1, 1, 1'b0, "R8");
    chk(q_data.size() == 0, "R9", "results never produced", q_data.size(), 0);
    chk(done_seen == 5, "R10", "total done pulses", done_seen, 5);
    finish_run();
  end
endmodule